// File: doc/BRIEF.md
# Whole-Cache Maintenance Sequencer

This block drives whole-cache maintenance for a small write-back data cache whose line states live in a separate state array. It accepts three kinds of request. The first is a hardware flush strobe. The second invalidates everything and discards dirty data. The third writes dirty data back and then invalidates. For each request it walks the state array one line index at a time and sends a write-back request for every Modified line when the operation calls for one. It then forces every line to Invalid and finishes by emitting the special bus cycles that tell a second-level cache what happened.

Each operation has its own order. A flush-strobe request writes dirty lines back, invalidates, and then issues a Flush Acknowledge cycle. An invalidate-only request clears lines without any write-back and then issues a Flush cycle. A write-back-invalidate request writes dirty lines back, invalidates, and then issues a Write Back cycle followed directly by a Flush cycle.

Write-back requests and special cycles each leave through a valid/ready port. Once valid is raised, the index or code stays put and valid stays high until ready is seen. Back-pressure on the write-back port stalls the scan at the dirty line. Back-pressure on the special-cycle port holds the current code. The request strobes, `busy` and `done` are plain level and pulse signals.

Top module: `cache_maint_seq`

## Requirements
- R1: After reset, `busy`, `done`, `wb_valid`, `sc_valid` and `st_wr_en` are 0 and `sc_code` is 00 (none).
- R2: A request strobe sampled while idle makes `busy` high from the next cycle. With both ready inputs held high, the walk visits indices 0 to N-1 in ascending order, one per cycle, so the first special cycle is offered exactly N cycles after `busy` rises.
- R3: A flush-strobe request raises one write-back for each line whose state is Modified (11), and for no other line. Each such line's write-back handshake comes before its invalidation. After the walk, exactly one special cycle with code Flush Acknowledge (10) is issued.
- R4: An invalidate-only request raises no write-back at all and issues exactly one special cycle with code Flush (01).
- R5: A write-back-invalidate request writes back every Modified line, as in R3, and then issues Write Back (11) followed by Flush (01), in that order.
- R6: During the walk every index receives exactly one state write, and its value is Invalid (00). Line state encoding: Invalid 00, Shared 01, Exclusive 10, Modified 11.
- R7: While `wb_valid` is high and `wb_ready` is low, `wb_valid` and `wb_idx` hold and no state write occurs.
- R8: While `sc_valid` is high and `sc_ready` is low, `sc_code` holds. `sc_code` is 00 whenever `sc_valid` is low.
- R9: Request strobes that arrive while `busy` is high are ignored: the operation in progress completes unchanged and no second operation follows.
- R10: `done` is a single-cycle pulse in the cycle after the last special-cycle handshake, once per operation.
- R11: Strobes raised in the same cycle are resolved by priority: flush strobe first, then write-back-invalidate, then invalidate-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_flush | input | 1 | Flush strobe request |
| req_inval | input | 1 | Invalidate-only request |
| req_wb_inval | input | 1 | Write-back-then-invalidate request |
| st_rd_idx | output | IDX_W | State array read index |
| st_rd_state | input | 2 | State of line `st_rd_idx`, same cycle |
| st_wr_en | output | 1 | State array write enable |
| st_wr_idx | output | IDX_W | State array write index |
| st_wr_state | output | 2 | State value to write (always Invalid) |
| wb_valid | output | 1 | Write-back request valid |
| wb_idx | output | IDX_W | Index of line to write back |
| wb_ready | input | 1 | Write-back accepted |
| sc_valid | output | 1 | Special cycle valid |
| sc_code | output | 2 | Special cycle code: 00 none, 01 Flush, 10 Flush Acknowledge, 11 Write Back |
| sc_ready | input | 1 | Special cycle accepted |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the ordering corners. A dirty line invalidated before its write-back is accepted would lose data under a flush or write-back-invalidate. Swapping or dropping the second special cycle of write-back-invalidate would leave the second-level cache dirty or valid. A write-back leaking out during invalidate-only would corrupt memory with discarded data. Random back-pressure on both ports exposes a scan that advances past a stalled dirty line or a code that changes before acceptance. Strobes fired mid-operation and in the same cycle expose a sequencer that restarts, chains a second run, or resolves priority wrongly.

// File: rtl/cmseq_pkg.sv
`timescale 1ns/1ps
package cmseq_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10,
    LS_MOD = 2'b11
  } line_st_t;

  typedef enum logic [1:0] {
    SC_NONE      = 2'b00,
    SC_FLUSH     = 2'b01,
    SC_FLUSH_ACK = 2'b10,
    SC_WRBACK    = 2'b11
  } spec_code_t;

  typedef enum logic [1:0] {
    OP_PIN = 2'b00,
    OP_INV = 2'b01,
    OP_WBI = 2'b10
  } maint_op_t;
endpackage

// File: rtl/cmseq_req_arb.sv
`timescale 1ns/1ps
module cmseq_req_arb
  import cmseq_pkg::*;
(
  input  logic      idle,
  input  logic      req_flush,
  input  logic      req_inval,
  input  logic      req_wb_inval,
  output logic      start,
  output maint_op_t op
);
  // Priority: flush strobe, then write-back-invalidate, then invalidate-only (R11)
  always_comb begin
    start = idle & (req_flush | req_inval | req_wb_inval);
    if (req_flush)         op = OP_PIN;
    else if (req_wb_inval) op = OP_WBI;
    else                   op = OP_INV;
  end
endmodule

// File: rtl/cmseq_line_walker.sv
`timescale 1ns/1ps
module cmseq_line_walker
  import cmseq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wb_mode,
  input  logic [1:0]       rd_state,
  input  logic             wb_ready,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [1:0]       wr_state,
  output logic             wb_valid,
  output logic [IDX_W-1:0] wb_idx,
  output logic             walking,
  output logic             walk_done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

  logic [IDX_W-1:0] idx_q;
  logic             wb_mode_q;
  logic             need_wb;
  logic             advance;

  always_comb begin
    need_wb   = walking && wb_mode_q && (line_st_t'(rd_state) == LS_MOD);
    advance   = walking && (!need_wb || wb_ready);
    rd_idx    = idx_q;
    wb_valid  = need_wb;
    wb_idx    = idx_q;
    wr_en     = advance;
    wr_idx    = idx_q;
    wr_state  = LS_INV;
    walk_done = advance && (idx_q == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walking   <= 1'b0;
      idx_q     <= '0;
      wb_mode_q <= 1'b0;
    end else if (start) begin
      walking   <= 1'b1;
      idx_q     <= '0;
      wb_mode_q <= wb_mode;
    end else if (advance) begin
      if (idx_q == LAST_IDX) walking <= 1'b0;
      else                   idx_q   <= idx_q + 1'b1;
    end
  end

  a_r7_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_idx)));
  a_r7_no_write_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |-> !wr_en);
  a_r3_wb_only_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (rd_state == 2'b11));
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && walking && !walk_done) |=> (wr_idx == $past(wr_idx) + 1'b1));
endmodule

// File: rtl/cmseq_special_emit.sv
`timescale 1ns/1ps
module cmseq_special_emit
  import cmseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  maint_op_t  op,
  input  logic       sc_ready,
  output logic       sc_valid,
  output logic [1:0] sc_code,
  output logic       emit_done
);
  typedef enum logic [1:0] {EM_IDLE, EM_FIRST, EM_SECOND} em_stage_t;
  em_stage_t stage_q;
  logic      fire;

  always_comb begin
    sc_valid = (stage_q != EM_IDLE);
    unique case (stage_q)
      EM_FIRST: begin
        unique case (op)
          OP_PIN:  sc_code = SC_FLUSH_ACK;
          OP_WBI:  sc_code = SC_WRBACK;
          default: sc_code = SC_FLUSH;
        endcase
      end
      EM_SECOND: sc_code = SC_FLUSH;
      default:   sc_code = SC_NONE;
    endcase
    fire      = sc_valid && sc_ready;
    emit_done = fire && !(stage_q == EM_FIRST && op == OP_WBI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= EM_IDLE;
    end else if (launch) begin
      stage_q <= EM_FIRST;
    end else if (fire) begin
      if (stage_q == EM_FIRST && op == OP_WBI) stage_q <= EM_SECOND;
      else                                     stage_q <= EM_IDLE;
    end
  end

  a_r8_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && !sc_ready) |=> (sc_valid && $stable(sc_code)));
  a_r5_flush_after_wrback: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sc_code == 2'b11) |=> (sc_valid && sc_code == 2'b01));
endmodule

// File: rtl/cache_maint_seq.sv
`timescale 1ns/1ps
module cache_maint_seq
  import cmseq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_flush,
  input  logic             req_inval,
  input  logic             req_wb_inval,
  output logic [IDX_W-1:0] st_rd_idx,
  input  logic [1:0]       st_rd_state,
  output logic             st_wr_en,
  output logic [IDX_W-1:0] st_wr_idx,
  output logic [1:0]       st_wr_state,
  output logic             wb_valid,
  output logic [IDX_W-1:0] wb_idx,
  input  logic             wb_ready,
  output logic             sc_valid,
  output logic [1:0]       sc_code,
  input  logic             sc_ready,
  output logic             busy,
  output logic             done
);
  logic      start;
  maint_op_t arb_op;
  maint_op_t op_q;
  logic      walking;
  logic      walk_done;
  logic      emit_done;
  logic      done_q;

  cmseq_req_arb u_arb (
    .idle         (!busy),
    .req_flush    (req_flush),
    .req_inval    (req_inval),
    .req_wb_inval (req_wb_inval),
    .start        (start),
    .op           (arb_op)
  );

  cmseq_line_walker #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wb_mode   (arb_op != OP_INV),
    .rd_state  (st_rd_state),
    .wb_ready  (wb_ready),
    .rd_idx    (st_rd_idx),
    .wr_en     (st_wr_en),
    .wr_idx    (st_wr_idx),
    .wr_state  (st_wr_state),
    .wb_valid  (wb_valid),
    .wb_idx    (wb_idx),
    .walking   (walking),
    .walk_done (walk_done)
  );

  cmseq_special_emit u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (walk_done),
    .op        (op_q),
    .sc_ready  (sc_ready),
    .sc_valid  (sc_valid),
    .sc_code   (sc_code),
    .emit_done (emit_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_INV;
      done_q <= 1'b0;
    end else begin
      if (start) op_q <= arb_op;
      done_q <= emit_done;
    end
  end

  assign busy = walking | sc_valid;
  assign done = done_q;

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  a_r4_inval_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_INV) |-> !wb_valid);
  a_r9_phases_apart: assert property (@(posedge clk) disable iff (!rst_n)
    walking |-> !sc_valid);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_special_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> sc_valid);
endmodule

// File: tb/cache_maint_seq_test.sv
`timescale 1ns/1ps
module cache_maint_seq_test;
  localparam int N  = 16;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_flush = 1'b0, req_inval = 1'b0, req_wb_inval = 1'b0;
  logic [IW-1:0] st_rd_idx, st_wr_idx, wb_idx;
  logic [1:0] st_rd_state, st_wr_state, sc_code;
  logic st_wr_en, wb_valid, wb_ready, sc_valid, sc_ready, busy, done;

  always #5 clk = ~clk;

  cache_maint_seq #(.NUM_LINES(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_flush(req_flush), .req_inval(req_inval),
    .req_wb_inval(req_wb_inval), .st_rd_idx(st_rd_idx), .st_rd_state(st_rd_state),
    .st_wr_en(st_wr_en), .st_wr_idx(st_wr_idx), .st_wr_state(st_wr_state),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_ready(wb_ready),
    .sc_valid(sc_valid), .sc_code(sc_code), .sc_ready(sc_ready),
    .busy(busy), .done(done)
  );

  // state array model
  logic [1:0] mem [N];
  assign st_rd_state = mem[st_rd_idx];
  always @(posedge clk) if (st_wr_en) mem[st_wr_idx] <= st_wr_state;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // ready generation
  logic [7:0] lfsr = 8'h5a;
  bit stall_mode = 1'b0;
  initial begin wb_ready = 1'b1; sc_ready = 1'b1; end
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wb_ready = stall_mode ? (lfsr[0] & lfsr[3]) : 1'b1;
    sc_ready = stall_mode ? (lfsr[2] & lfsr[5]) : 1'b1;
  end

  int nvec = 0, nfail = 0;
  task automatic chk(input string req, input string what, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor
  bit wb_seen [N];
  bit expect_wb;
  int wb_cnt, wr_cnt, wr_nonI, exp_idx, seq_err, order_err, wb_hold_err, stall_wr_err;
  int sc_hold_err, sc_idle_err, sc_n, done_cnt, done_cyc, last_sc_cyc, first_sc_cyc;
  int sc_log [4];
  bit prev_wb_stall, prev_sc_stall;
  logic [IW-1:0] prev_wb_idx;
  logic [1:0] prev_code;

  always @(negedge clk) if (rst_n) begin
    if (prev_wb_stall && (!wb_valid || wb_idx != prev_wb_idx)) wb_hold_err++;
    if (prev_sc_stall && (!sc_valid || sc_code != prev_code)) sc_hold_err++;
    if (!sc_valid && sc_code != 2'b00) sc_idle_err++;
    if (wb_valid && !wb_ready && st_wr_en) stall_wr_err++;
    if (wb_valid && wb_ready) begin wb_seen[wb_idx] = 1'b1; wb_cnt++; end
    if (st_wr_en) begin
      if (expect_wb && mem[st_wr_idx] == 2'b11 && !wb_seen[st_wr_idx]) order_err++;
      if (int'(st_wr_idx) != exp_idx) seq_err++;
      if (st_wr_state != 2'b00) wr_nonI++;
      exp_idx++; wr_cnt++;
    end
    if (sc_valid && first_sc_cyc < 0) first_sc_cyc = cyc;
    if (sc_valid && sc_ready) begin
      if (sc_n < 4) sc_log[sc_n] = int'(sc_code);
      sc_n++; last_sc_cyc = cyc;
    end
    if (done) begin done_cnt++; done_cyc = cyc; end
    prev_wb_stall = wb_valid && !wb_ready; prev_wb_idx = wb_idx;
    prev_sc_stall = sc_valid && !sc_ready; prev_code = sc_code;
  end

  function automatic logic [1:0] pat(input int i, input int seed);
    if (seed == 0) return 2'b11;
    if (seed == 1) return 2'(i % 3);
    return 2'(((i * 7 + seed * 3) ^ (i >> 1)) % 4);
  endfunction

  // which: 0 flush strobe, 1 invalidate-only, 2 write-back-invalidate
  task automatic run_op(input string req, input bit f, input bit iv, input bit wbi,
                        input int seed, input bit stall, input bit interfere);
    int op, t, start_cyc, bad_wb, not_inv;
    bit dirty [N];
    op = f ? 0 : (wbi ? 2 : 1);
    @(posedge clk); #2;
    for (int i = 0; i < N; i++) begin mem[i] = pat(i, seed); dirty[i] = (mem[i] == 2'b11); wb_seen[i] = 1'b0; end
    expect_wb = (op != 1);
    wb_cnt = 0; wr_cnt = 0; wr_nonI = 0; exp_idx = 0; seq_err = 0; order_err = 0;
    wb_hold_err = 0; stall_wr_err = 0; sc_hold_err = 0; sc_idle_err = 0;
    sc_n = 0; done_cnt = 0; done_cyc = -1; last_sc_cyc = -1; first_sc_cyc = -1;
    stall_mode = stall;
    req_flush = f; req_inval = iv; req_wb_inval = wbi;
    @(posedge clk); #2;
    req_flush = 0; req_inval = 0; req_wb_inval = 0;
    @(negedge clk);
    start_cyc = cyc;
    chk("R2", {req, " busy after strobe"}, int'(busy), 1);
    if (interfere) begin
      repeat (3) @(posedge clk); #2;
      req_flush = 1; req_inval = 1; req_wb_inval = 1;
      @(posedge clk); #2;
      req_flush = 0; req_inval = 0; req_wb_inval = 0;
    end
    t = 0;
    while (done_cnt == 0 && t < 5000) begin @(negedge clk); t++; end
    repeat (N + 6) @(negedge clk);
    stall_mode = 1'b0;
    bad_wb = 0; not_inv = 0;
    for (int i = 0; i < N; i++) begin
      if (wb_seen[i] != (expect_wb && dirty[i])) bad_wb++;
      if (mem[i] != 2'b00) not_inv++;
    end
    if (op == 1) chk("R4", {req, " write-backs"}, wb_cnt, 0);
    else         chk("R3", {req, " write-back set mismatches"}, bad_wb, 0);
    chk("R3", {req, " invalidated before write-back"}, order_err, 0);
    chk("R6", {req, " lines not Invalid"}, not_inv, 0);
    chk("R6", {req, " state writes"}, wr_cnt, N);
    chk("R6", {req, " non-Invalid write value"}, wr_nonI, 0);
    chk("R2", {req, " index order errors"}, seq_err, 0);
    if (op == 2) begin
      chk("R5", {req, " special count"}, sc_n, 2);
      chk("R5", {req, " first special"}, sc_log[0], 3);
      chk("R5", {req, " second special"}, sc_log[1], 1);
    end else begin
      chk(op == 0 ? "R3" : "R4", {req, " special count"}, sc_n, 1);
      chk(op == 0 ? "R3" : "R4", {req, " special code"}, sc_log[0], op == 0 ? 2 : 1);
    end
    chk("R10", {req, " done pulses"}, done_cnt, 1);
    chk("R10", {req, " done timing"}, done_cyc, last_sc_cyc + 1);
    chk("R7", {req, " write-back hold errors"}, wb_hold_err + stall_wr_err, 0);
    chk("R8", {req, " special hold errors"}, sc_hold_err + sc_idle_err, 0);
    chk("R9", {req, " idle at end"}, int'(busy), 0);
    if (!stall) chk("R2", {req, " walk length"}, first_sc_cyc - start_cyc, N);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "wb_valid", int'(wb_valid), 0);
    chk("R1", "sc_valid", int'(sc_valid), 0);
    chk("R1", "sc_code", int'(sc_code), 0);
    chk("R1", "st_wr_en", int'(st_wr_en), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) mem[i] = 2'b00;
    t_reset();
    run_op("R3 flush all dirty",       1, 0, 0, 0, 0, 0);
    run_op("R3 flush mixed stalled",   1, 0, 0, 5, 1, 0);
    run_op("R4 inval all dirty",       0, 1, 0, 0, 0, 0);
    run_op("R4 inval mixed stalled",   0, 1, 0, 9, 1, 0);
    run_op("R5 wbinval no dirty",      0, 0, 1, 1, 0, 0);
    run_op("R5 wbinval mixed stalled", 0, 0, 1, 7, 1, 0);
    run_op("R9 wbinval interfered",    0, 0, 1, 3, 0, 1);
    run_op("R9 inval interfered",      0, 1, 0, 4, 1, 1);
    run_op("R11 flush+inval",          1, 1, 0, 6, 0, 0);
    run_op("R11 wbinval+inval",        0, 1, 1, 2, 0, 0);
    run_op("R11 all three",            1, 1, 1, 8, 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #1500000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule